// File: doc/BRIEF.md
# Power-Loss Emergency Flush Sequencer

This block watches a digitized supply-voltage sample and, when the supply sags, drives a storage controller through an orderly shutdown on hold-up energy. A sample below the programmable trip level counts toward a debounce run. Samples in a hysteresis band above the trip level neither advance nor clear that run, so a noisy supply near the threshold does not defeat detection. Once the run reaches its required length, host write acceptance and all new flash work, background jobs included, are blocked, and the hold-up energy source is switched on.

The sequencer then waits for any page program already under way to finish. That program may be on a lower or an upper page. Cutting an upper-page program short can damage its paired lower page, so it is always allowed to complete. In full mode the block then asks for the volatile write buffer to be flushed, then for the address translation table to be saved. Each request is ended by a done strobe from the controller. In reduced mode, which suits a small hold-up reserve, only program completion is performed and the table is rebuilt at the next boot.

A cycle counter bounds the whole sequence against a programmable budget. If the budget runs out first, the block stops in a terminal incomplete state. Once the sequence has started it runs to its end whatever the supply does, and only reset returns the block to idle.

Top module: `plf_flush_seq`

## Requirements
- R1: After reset every output is 0.
- R2: A sample is low when `vsup_sample < trip_level`. Each low sample at a clock edge advances a debounce count, and the blocking outputs rise in the cycle after the DEBOUNCE_N-th consecutive low sample (default 4). A high sample clears the count. A high sample is one with `vsup_sample >= trip_level + hyst_margin`, computed without overflow.
- R3: A sample in the band `trip_level <= vsup_sample < trip_level + hyst_margin` leaves the debounce count unchanged.
- R4: On detection, `host_wr_block`, `flash_issue_block` and `holdup_en` rise in the same cycle and stay high until reset.
- R5: `flush_req` does not rise while `prog_busy` is 1. It rises in the cycle after an edge at which `prog_busy` is 0 during the drain phase.
- R6: In full mode, `flush_req` stays high until the edge at which `flush_done` is 1. `map_req` then stays high until the edge at which `map_done` is 1, and after that `seq_done` rises. `flush_req` and `map_req` are never high together.
- R7: In reduced mode, once programs have drained, `seq_done` rises directly, and `flush_req` and `map_req` never assert.
- R8: `reduced_mode` (1 = reduced, 0 = full) is captured at the edge where the sequence leaves idle. Later changes to it have no effect.
- R9: The budget value is captured at the same edge as the mode. The first active cycle has count 0, and the count rises by one per cycle. If the cycle where the count equals the budget ends without the current phase completing, `seq_incomplete` rises. That state is terminal, with both requests low.
- R10: Recovery of the supply after detection does not abort or pause the sequence.
- R11: A phase completion that arrives in the cycle where the count equals the budget is honoured instead of the expiry.
- R12: `seq_done` and `seq_incomplete` are never high together, and each stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsup_sample | input | SAMPLE_W | Digitized supply voltage |
| trip_level | input | SAMPLE_W | Threshold below which a sample is low |
| hyst_margin | input | SAMPLE_W | Band above the threshold that does not clear the debounce |
| reduced_mode | input | 1 | 1 = program completion only, 0 = full shutdown |
| budget | input | BUDGET_W | Hold-up budget in clock cycles |
| prog_busy | input | 1 | A flash page program is in progress |
| flush_done | input | 1 | Buffer flush finished |
| map_done | input | 1 | Translation table saved |
| host_wr_block | output | 1 | Refuse new host write commands |
| flash_issue_block | output | 1 | Start no new flash operations, background ones included |
| holdup_en | output | 1 | Enable hold-up energy discharge |
| flush_req | output | 1 | Request buffer flush |
| map_req | output | 1 | Request translation table save |
| seq_done | output | 1 | All phases completed |
| seq_incomplete | output | 1 | Budget ran out before completion |

## Verification
The properties assume that the controller asserts `flush_done` and `map_done` only while the matching request is high, and that the threshold inputs stay stable. This matters because the property tying detection to a low sample compares `vsup_sample` against `trip_level` one cycle back. The stimulus changes the trip, margin and budget settings only while reset is held, and it raises each done strobe only after it has seen the matching request. Supply samples are changed on the falling edge, so the debounce count and the budget cycle number can be worked out exactly for every check.

// File: rtl/plf_pkg.sv
package plf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DRAIN = 3'd1,
        ST_FLUSH = 3'd2,
        ST_MAP   = 3'd3,
        ST_DONE  = 3'd4,
        ST_FAIL  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/plf_supply_mon.sv
module plf_supply_mon #(
    parameter int SAMPLE_W   = 10,
    parameter int DEBOUNCE_N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [SAMPLE_W-1:0] trip_i,
    input  logic [SAMPLE_W-1:0] margin_i,
    output logic                trip_o
);
    localparam int CNT_W = $clog2(DEBOUNCE_N + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEBOUNCE_N);

    typedef struct packed {
        logic [CNT_W-1:0] run;
    } mon_t;

    mon_t mon_d, mon_q;
    logic is_low;
    logic is_high;
    logic [SAMPLE_W:0] release_lvl;

    always_comb begin
        mon_d       = mon_q;
        release_lvl = {1'b0, trip_i} + {1'b0, margin_i};
        is_low      = sample_i < trip_i;
        is_high     = {1'b0, sample_i} >= release_lvl;
        if (is_low) begin
            if (mon_q.run != CNT_FULL) begin
                mon_d.run = mon_q.run + 1'b1;
            end
        end else if (is_high) begin
            mon_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign trip_o = (mon_q.run == CNT_FULL);

endmodule

// File: rtl/plf_holdup_timer.sv
module plf_holdup_timer #(
    parameter int BUDGET_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                run_i,
    input  logic [BUDGET_W-1:0] budget_i,
    output logic                expired_o
);
    typedef struct packed {
        logic [BUDGET_W-1:0] count;
        logic [BUDGET_W-1:0] limit;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clear_i) begin
            tmr_d.count = '0;
            tmr_d.limit = budget_i;
        end else if (run_i && (tmr_q.count != tmr_q.limit)) begin
            tmr_d.count = tmr_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired_o = run_i && (tmr_q.count == tmr_q.limit);

endmodule

// File: rtl/plf_flush_seq.sv
module plf_flush_seq
    import plf_pkg::*;
#(
    parameter int SAMPLE_W   = 10,
    parameter int DEBOUNCE_N = 4,
    parameter int BUDGET_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] vsup_sample,
    input  logic [SAMPLE_W-1:0] trip_level,
    input  logic [SAMPLE_W-1:0] hyst_margin,
    input  logic                reduced_mode,
    input  logic [BUDGET_W-1:0] budget,
    input  logic                prog_busy,
    input  logic                flush_done,
    input  logic                map_done,
    output logic                host_wr_block,
    output logic                flash_issue_block,
    output logic                holdup_en,
    output logic                flush_req,
    output logic                map_req,
    output logic                seq_done,
    output logic                seq_incomplete
);
    typedef struct packed {
        seq_state_e st;
        logic       reduced;
    } seq_t;

    seq_t seq_d, seq_q;
    logic trip;
    logic expired;
    logic active;
    logic start;

    plf_supply_mon #(
        .SAMPLE_W  (SAMPLE_W),
        .DEBOUNCE_N(DEBOUNCE_N)
    ) i_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample_i(vsup_sample),
        .trip_i  (trip_level),
        .margin_i(hyst_margin),
        .trip_o  (trip)
    );

    assign active = (seq_q.st == ST_DRAIN) || (seq_q.st == ST_FLUSH) || (seq_q.st == ST_MAP);
    assign start  = (seq_q.st == ST_IDLE) && trip;

    plf_holdup_timer #(
        .BUDGET_W(BUDGET_W)
    ) i_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start),
        .run_i    (active),
        .budget_i (budget),
        .expired_o(expired)
    );

    // Completion handshakes take precedence over budget expiry.
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (trip) begin
                    seq_d.st      = ST_DRAIN;
                    seq_d.reduced = reduced_mode;
                end
            end
            ST_DRAIN: begin
                if (!prog_busy) begin
                    seq_d.st = seq_q.reduced ? ST_DONE : ST_FLUSH;
                end else if (expired) begin
                    seq_d.st = ST_FAIL;
                end
            end
            ST_FLUSH: begin
                if (flush_done) begin
                    seq_d.st = ST_MAP;
                end else if (expired) begin
                    seq_d.st = ST_FAIL;
                end
            end
            ST_MAP: begin
                if (map_done) begin
                    seq_d.st = ST_DONE;
                end else if (expired) begin
                    seq_d.st = ST_FAIL;
                end
            end
            ST_DONE: seq_d.st = ST_DONE;
            ST_FAIL: seq_d.st = ST_FAIL;
            default: seq_d.st = ST_FAIL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, reduced: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign host_wr_block     = start || (seq_q.st != ST_IDLE);
    assign flash_issue_block = start || (seq_q.st != ST_IDLE);
    assign holdup_en         = start || (seq_q.st != ST_IDLE);
    assign flush_req         = (seq_q.st == ST_FLUSH);
    assign map_req           = (seq_q.st == ST_MAP);
    assign seq_done          = (seq_q.st == ST_DONE);
    assign seq_incomplete    = (seq_q.st == ST_FAIL);

endmodule

// File: rtl/plf_seq_chk.sv
module plf_seq_chk #(
    parameter int SAMPLE_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic [SAMPLE_W-1:0] vsup_sample,
    input logic [SAMPLE_W-1:0] trip_level,
    input logic                prog_busy,
    input logic                flush_done,
    input logic                host_wr_block,
    input logic                flash_issue_block,
    input logic                holdup_en,
    input logic                flush_req,
    input logic                map_req,
    input logic                seq_done,
    input logic                seq_incomplete
);

    // R2: detection follows a sample below the trip level
    p_detect_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_wr_block) |-> $past(vsup_sample < trip_level));

    // R4: gating is sticky
    p_gates_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_block && flash_issue_block && holdup_en)
            |=> (host_wr_block && flash_issue_block && holdup_en));

    // R5: no flush while a program was running
    p_flush_after_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> $past(!prog_busy));

    // R6: map save follows a finished flush
    p_map_after_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(map_req) |-> $past(flush_req && flush_done));

    // R6: requests are exclusive
    p_req_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_req, map_req}));

    // R12: terminal outcomes are exclusive and sticky
    p_term_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done && seq_incomplete));

    p_done_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> seq_done);

    // R9: incomplete is terminal with no requests
    p_fail_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_incomplete |=> (seq_incomplete && !flush_req && !map_req));

endmodule

bind plf_flush_seq plf_seq_chk #(.SAMPLE_W(SAMPLE_W)) i_plf_seq_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .vsup_sample      (vsup_sample),
    .trip_level       (trip_level),
    .prog_busy        (prog_busy),
    .flush_done       (flush_done),
    .host_wr_block    (host_wr_block),
    .flash_issue_block(flash_issue_block),
    .holdup_en        (holdup_en),
    .flush_req        (flush_req),
    .map_req          (map_req),
    .seq_done         (seq_done),
    .seq_incomplete   (seq_incomplete)
);

// File: tb/test_plf_flush_seq.sv
`timescale 1ns/1ps
module test_plf_flush_seq;
    localparam int SW = 10;
    localparam int BW = 16;
    localparam logic [SW-1:0] V_HIGH = 10'd700;
    localparam logic [SW-1:0] V_LOW  = 10'd400;
    localparam logic [SW-1:0] V_MID  = 10'd520;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SW-1:0] vsup_sample = V_HIGH;
    logic [SW-1:0] trip_level = 10'd500;
    logic [SW-1:0] hyst_margin = 10'd40;
    logic reduced_mode = 1'b0;
    logic [BW-1:0] budget = 16'd1000;
    logic prog_busy = 1'b0;
    logic flush_done = 1'b0;
    logic map_done = 1'b0;
    logic host_wr_block, flash_issue_block, holdup_en;
    logic flush_req, map_req, seq_done, seq_incomplete;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    plf_flush_seq #(.SAMPLE_W(SW), .DEBOUNCE_N(4), .BUDGET_W(BW)) i_plf_flush_seq (
        .clk(clk), .rst_n(rst_n), .vsup_sample(vsup_sample), .trip_level(trip_level),
        .hyst_margin(hyst_margin), .reduced_mode(reduced_mode), .budget(budget),
        .prog_busy(prog_busy), .flush_done(flush_done), .map_done(map_done),
        .host_wr_block(host_wr_block), .flash_issue_block(flash_issue_block),
        .holdup_en(holdup_en), .flush_req(flush_req), .map_req(map_req),
        .seq_done(seq_done), .seq_incomplete(seq_incomplete)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic feed(input logic [SW-1:0] v, input int n);
        vsup_sample = v;
        step(n);
    endtask

    function automatic logic [2:0] gates();
        return {host_wr_block, flash_issue_block, holdup_en};
    endfunction

    task automatic do_reset(input logic red, input logic [BW-1:0] bud, input logic busy);
        @(negedge clk);
        rst_n = 1'b0;
        vsup_sample = V_HIGH;
        reduced_mode = red;
        budget = bud;
        prog_busy = busy;
        flush_done = 1'b0;
        map_done = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        do_reset(1'b0, 16'd1000, 1'b0);
        chk("R1 gates", 32'(gates()), 32'd0);
        chk("R1 reqs", 32'({flush_req, map_req}), 32'd0);
        chk("R1 status", 32'({seq_done, seq_incomplete}), 32'd0);
    endtask

    task automatic t_glitch();
        do_reset(1'b0, 16'd1000, 1'b1);
        feed(V_LOW, 3);
        feed(V_HIGH, 1);
        feed(V_LOW, 3);
        chk("R2 high sample clears run", 32'(host_wr_block), 32'd0);
        feed(V_LOW, 1);
        chk("R2 fourth low detects", 32'(host_wr_block), 32'd1);
        chk("R4 gates together", 32'(gates()), 32'd7);
    endtask

    task automatic t_hyst();
        do_reset(1'b0, 16'd1000, 1'b1);
        feed(V_LOW, 2);
        feed(V_MID, 3);
        feed(V_LOW, 1);
        chk("R3 band holds count", 32'(host_wr_block), 32'd0);
        feed(V_LOW, 1);
        chk("R3 band kept count", 32'(host_wr_block), 32'd1);
    endtask

    task automatic t_full();
        do_reset(1'b0, 16'd1000, 1'b1);
        feed(V_LOW, 4);
        chk("R4 gates on detect", 32'(gates()), 32'd7);
        step(1);
        reduced_mode = 1'b1;
        feed(V_HIGH, 5);
        chk("R10 recovery keeps gates", 32'(gates()), 32'd7);
        chk("R5 no flush while busy", 32'(flush_req), 32'd0);
        prog_busy = 1'b0;
        step(1);
        chk("R5 flush after drain", 32'(flush_req), 32'd1);
        chk("R8 late mode ignored", 32'(seq_done), 32'd0);
        step(3);
        chk("R6 flush held", 32'({flush_req, map_req}), 32'd2);
        flush_done = 1'b1;
        step(1);
        flush_done = 1'b0;
        chk("R6 map after flush", 32'({flush_req, map_req}), 32'd1);
        step(2);
        chk("R6 map held", 32'({map_req, seq_done}), 32'd2);
        map_done = 1'b1;
        step(1);
        map_done = 1'b0;
        chk("R6 done after map", 32'({map_req, seq_done}), 32'd1);
        step(5);
        chk("R12 done sticky", 32'({seq_done, seq_incomplete}), 32'd2);
        chk("R4 gates sticky", 32'(gates()), 32'd7);
    endtask

    task automatic t_reduced();
        do_reset(1'b1, 16'd1000, 1'b1);
        feed(V_LOW, 4);
        step(1);
        reduced_mode = 1'b0;
        step(3);
        chk("R7 no flush in drain", 32'(flush_req), 32'd0);
        prog_busy = 1'b0;
        step(1);
        chk("R7 done after drain", 32'(seq_done), 32'd1);
        chk("R8 mode captured", 32'({flush_req, map_req}), 32'd0);
        step(3);
        chk("R7 never requests", 32'({flush_req, map_req}), 32'd0);
    endtask

    task automatic t_expire();
        do_reset(1'b0, 16'd10, 1'b1);
        feed(V_LOW, 4);
        step(1);
        step(10);
        chk("R9 not yet expired", 32'(seq_incomplete), 32'd0);
        step(1);
        chk("R9 expired", 32'({seq_done, seq_incomplete}), 32'd1);
        prog_busy = 1'b0;
        step(3);
        chk("R9 terminal", 32'({flush_req, map_req, seq_incomplete}), 32'd1);
        chk("R12 incomplete sticky", 32'(seq_done), 32'd0);
    endtask

    task automatic t_race();
        do_reset(1'b1, 16'd10, 1'b1);
        feed(V_LOW, 4);
        step(1);
        step(10);
        prog_busy = 1'b0;
        step(1);
        chk("R11 completion wins", 32'({seq_done, seq_incomplete}), 32'd2);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        t_reset();
        t_glitch();
        t_hyst();
        t_full();
        t_reduced();
        t_expire();
        t_race();
        finish_run();
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

endmodule